// File: doc/BRIEF.md
# Serial Byte Transmitter with Completion Flags

This block sends bytes over an asynchronous serial line. Software drives it through three small registers: a data register that takes the next byte, a status register that reports whether the byte holder is free and whether the line has gone quiet, and a control register with five enables. Bit timing comes from a shared oversampling strobe (`baud_tick`), and every bit on the line lasts a fixed number of strobes.

When transmission is switched on, the block first holds the line high for one whole frame. This idle frame warns the far end before any data arrives. After that, each byte written is moved into a shift register and sent as a start bit, the data bits and a stop bit. A byte only starts when the block is enabled and, if flow control is on, when the clear-to-send input is low.

Two flags drive the software flow:
- The empty flag says a new byte may be written. In DMA mode it is also presented as a request line.
- The done flag says the last frame has fully left the wire. It is cleared by a status read followed by a data write, or by a direct write of zero while DMA mode is on.

An optional clock output gives one pulse per data bit for a receiver that needs a clock.

Top module: `sertx_top`

## Requirements
- R1: After reset, TX is high, `ck` and `dma_req` are low, and a status read returns 0x03. The register map is: address 0 = data, address 1 = status, address 2 = control. In the status register, bit 0 is the empty flag and bit 1 is the done flag.
- R2: Each data frame has this form:
  - one low start bit;
  - the data bits, least significant first;
  - one high stop bit.
  Each bit lasts OVS (16) baud ticks.
- R3: When the effective transmit enable rises, one idle frame goes out before any data frame. The idle frame is the line high for a full frame time (160 ticks). The effective transmit enable is control bit 0 (global) AND control bit 1 (transmit).
- R4: A data write clears the empty flag. The flag is set again when the byte moves into the shift register.
- R5: The done flag is set when a frame ends while the empty flag is set. It is never set while a byte is waiting.
- R6: A status read that returns done = 1, followed later by a data write, clears the done flag. A data write with no such prior read leaves the done flag unchanged.
- R7: A status write with bit 1 = 0 clears the done flag only when DMA enable (control bit 2) is set. Otherwise the write has no effect.
- R8: `dma_req` is high exactly when DMA enable is set and the empty flag is set.
- R9: When clock output (control bit 4) is set, `ck` gives one pulse per data bit. That is DATA_W rising edges per data frame, and none during start, stop or idle frames. When control bit 4 is clear, `ck` stays low.
- R10: When flow control (control bit 3) is set and `cts_n` is high, no frame starts. A frame already under way always completes.
- R11: Clearing the transmit enable during a frame does not cut that frame short. After the frame ends, no new frame starts while the enable stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Oversampling strobe from the shared rate generator |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DATA_W | Read data, valid the cycle after `rd_en` |
| cts_n | input | 1 | Clear-to-send, active low |
| tx | output | 1 | Serial data out |
| ck | output | 1 | Bit clock out |
| dma_req | output | 1 | Request for the next byte in DMA mode |

## Verification
The bench decodes every frame that appears on TX and compares it with the byte it wrote. It also measures the delay from each enable edge to the first start bit, which exposes a missing or shortened idle frame.

The done flag gets targeted tests:
- a data write with no prior status read must leave the flag set, so a design that clears on any write fails;
- a zero written to the status register with DMA off must change nothing;
- the same zero with DMA on must clear the flag.

The remaining tests cover the gating and the outputs:
- A byte held back by CTS must stay in the buffer for a long interval. The bench then raises CTS partway through a later frame, and that frame must still arrive intact.
- Transmit is disabled mid-frame; that frame must still arrive intact, and a later byte must not go out.
- Counting `ck` edges per frame catches pulses on the start or stop bits, or pulses when the clock output is disabled.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;

  localparam int ST_EMPTY = 0;
  localparam int ST_DONE  = 1;
  localparam int CTL_W    = 5;

  // control register, bit 0 = global_en ... bit 4 = ck_en
  typedef struct packed {
    logic ck_en;
    logic flow_en;
    logic dma_en;
    logic tx_en;
    logic global_en;
  } ctl_t;
endpackage

// File: rtl/sertx_regs.sv
module sertx_regs
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              load,
  input  logic              frame_end,
  output logic [DATA_W-1:0] data_q,
  output logic              buf_empty,
  output logic              done,
  output ctl_t              ctl
);
  logic armed;
  logic dwr, swr, cwr, srd;

  assign dwr = wr_en && (wr_addr == A_DATA);
  assign swr = wr_en && (wr_addr == A_STAT);
  assign cwr = wr_en && (wr_addr == A_CTRL);
  assign srd = rd_en && (rd_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q    <= '0;
      buf_empty <= 1'b1;
      done      <= 1'b1;
      armed     <= 1'b0;
      ctl       <= '0;
      rd_data   <= '0;
    end else begin
      if (load) buf_empty <= 1'b1;
      if (dwr) begin
        data_q    <= wr_data;
        buf_empty <= 1'b0;
      end
      if (cwr) ctl <= ctl_t'(wr_data[CTL_W-1:0]);

      if (frame_end && buf_empty && !dwr)               done <= 1'b1;
      else if (dwr && armed)                             done <= 1'b0;
      else if (swr && !wr_data[ST_DONE] && ctl.dma_en)   done <= 1'b0;

      if (dwr)              armed <= 1'b0;
      else if (srd && done) armed <= 1'b1;

      if (rd_en) begin
        case (rd_addr)
          A_DATA:  rd_data <= data_q;
          A_STAT:  rd_data <= DATA_W'({done, buf_empty});
          A_CTRL:  rd_data <= DATA_W'(ctl);
          default: rd_data <= '0;
        endcase
      end
    end
  end

  // R5: done only rises with nothing waiting
  a_r5_done_needs_empty: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> buf_empty);

  // R6 / R7: done only falls through one of the two clear paths
  a_r6_done_clear_path: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> ($past(dwr && armed) || $past(swr && !wr_data[ST_DONE] && ctl.dma_en)));

  // R4: empty only falls after a data write
  a_r4_empty_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(buf_empty) |-> $past(dwr));
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              en_run,
  input  logic              flow_en,
  input  logic              cts_n,
  input  logic              ck_en,
  input  logic              buf_empty,
  input  logic [DATA_W-1:0] data_q,
  output logic              load,
  output logic              frame_end,
  output logic              tx,
  output logic              ck
);
  localparam int FRAME_BITS = DATA_W + 2;
  localparam int TW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [TW-1:0] T_LAST = TW'(OVS - 1);
  localparam logic [TW-1:0] T_HALF = TW'(OVS / 2);
  localparam logic [BW-1:0] B_LAST = BW'(FRAME_BITS - 1);
  localparam logic [BW-1:0] B_DLO  = BW'(1);
  localparam logic [BW-1:0] B_DHI  = BW'(DATA_W);

  logic [FRAME_BITS-1:0] shreg;
  logic [TW-1:0]         tcnt;
  logic [BW-1:0]         bcnt;
  logic                  busy, is_data, en_eff, idle_pend;
  logic                  start_ok, start_idle, start_data, bit_end;

  assign start_ok   = !busy && en_eff && en_run && (!flow_en || !cts_n);
  assign start_idle = start_ok && idle_pend;
  assign start_data = start_ok && !idle_pend && !buf_empty;
  assign bit_end    = busy && baud_tick && (tcnt == T_LAST);
  assign frame_end  = bit_end && (bcnt == B_LAST);
  assign load       = start_data;
  assign tx         = shreg[0];
  assign ck         = ck_en && busy && is_data && (bcnt >= B_DLO) && (bcnt <= B_DHI)
                      && (tcnt >= T_HALF);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '1;
      tcnt      <= '0;
      bcnt      <= '0;
      busy      <= 1'b0;
      is_data   <= 1'b0;
      en_eff    <= 1'b0;
      idle_pend <= 1'b0;
    end else begin
      if (!busy) begin
        en_eff <= en_run;
        if (en_run && !en_eff) idle_pend <= 1'b1;
        else if (!en_run)      idle_pend <= 1'b0;
      end
      if (start_idle) begin
        busy      <= 1'b1;
        is_data   <= 1'b0;
        shreg     <= '1;
        tcnt      <= '0;
        bcnt      <= '0;
        idle_pend <= 1'b0;
      end else if (start_data) begin
        busy    <= 1'b1;
        is_data <= 1'b1;
        shreg   <= {1'b1, data_q, 1'b0};
        tcnt    <= '0;
        bcnt    <= '0;
      end else if (busy && baud_tick) begin
        if (bit_end) begin
          tcnt  <= '0;
          shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
          if (bcnt == B_LAST) begin
            busy <= 1'b0;
            bcnt <= '0;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end

  // R2: a data frame opens with a low start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
    start_data |=> (busy && !tx));

  // R3: the idle frame keeps the line high
  a_r3_idle_high: assert property (@(posedge clk) disable iff (rst)
    start_idle |=> (busy && tx));

  // R10: no frame starts while CTS holds it off
  a_r10_cts_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && flow_en && cts_n) |=> !busy);

  // R11: no frame starts while disabled
  a_r11_no_start_off: assert property (@(posedge clk) disable iff (rst)
    (!busy && !en_run) |=> !busy);
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cts_n,
  output logic              tx,
  output logic              ck,
  output logic              dma_req
);
  ctl_t              ctl;
  logic [DATA_W-1:0] data_q;
  logic              buf_empty, done, load, frame_end;

  sertx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .load(load), .frame_end(frame_end),
    .data_q(data_q), .buf_empty(buf_empty), .done(done), .ctl(ctl)
  );

  sertx_shift #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
    .clk(clk), .rst(rst), .baud_tick(baud_tick),
    .en_run(ctl.global_en && ctl.tx_en),
    .flow_en(ctl.flow_en), .cts_n(cts_n), .ck_en(ctl.ck_en),
    .buf_empty(buf_empty), .data_q(data_q),
    .load(load), .frame_end(frame_end), .tx(tx), .ck(ck)
  );

  assign dma_req = ctl.dma_en && buf_empty;

  // R1: reset state of the line and of both flags
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (tx && buf_empty && done && !dma_req));
endmodule

// File: tb/sertx_top_tb.sv
module sertx_top_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1, baud_tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0, cts_n = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       tx, ck, dma_req;

  sertx_top #(.DATA_W(8), .OVS(16)) u_dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .cts_n(cts_n), .tx(tx), .ck(ck), .dma_req(dma_req)
  );

  int     total = 0, bad = 0;
  longint cyc = 0;
  int     tdiv = 0;
  int     ck_rises = 0;
  logic   ck_q = 1'b0;

  always @(posedge clk) begin
    cyc       <= cyc + 1;
    tdiv      <= (tdiv == 3) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == 3);
  end

  always @(negedge clk) begin
    ck_q <= ck;
    if (ck && !ck_q) ck_rises <= ck_rises + 1;
  end

  // behavioural line decoder: one bit = 16 ticks = 64 clocks
  logic [7:0] dec_q[$];
  longint     dec_t[$];
  bit         dec_ok[$];

  initial begin
    logic       prev;
    logic [7:0] b;
    bit         ok;
    longint     t0;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (!rst && prev && !tx) begin
        t0 = cyc;
        ok = 1'b1;
        repeat (31) @(negedge clk);
        if (tx !== 1'b0) ok = 1'b0;
        for (int i = 0; i < 8; i++) begin
          repeat (64) @(negedge clk);
          b[i] = tx;
        end
        repeat (64) @(negedge clk);
        if (tx !== 1'b1) ok = 1'b0;
        dec_q.push_back(b);
        dec_t.push_back(t0);
        dec_ok.push_back(ok);
      end
      prev = tx;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_dec(input int n);
    int k;
    k = 0;
    while (dec_q.size() < n && k < 3000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] s;
    longint     t_en;
    int         r0;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 tx idle", tx, 1);
    chk("R1 dma_req", dma_req, 0);
    chk("R1 ck", ck, 0);
    rd(2'd1, s);
    chk("R1 status", s, 8'h03);

    // R3/R4/R6: enable, byte written during idle frame
    t_en = cyc;
    wr(2'd2, 8'h03);
    wr(2'd0, 8'hA5);
    rd(2'd1, s);
    chk("R4 empty cleared by write", s[0], 0);
    chk("R6 read then write clears done", s[1], 0);
    wait_dec(1);
    chk("R2 byte A5", (dec_q.size() > 0) ? dec_q[0] : 0, 8'hA5);
    chk("R2 frame shape A5", (dec_ok.size() > 0) ? dec_ok[0] : 0, 1);
    chk("R3 idle frame before data",
        (dec_t.size() > 0) && (dec_t[0] - t_en >= 600) && (dec_t[0] - t_en <= 730), 1);
    idle(700);
    rd(2'd1, s);
    chk("R4 empty set after load", s[0], 1);
    chk("R5 done after last frame", s[1], 1);

    // R7 write zero without DMA: no effect
    wr(2'd1, 8'h00);
    rd(2'd1, s);
    chk("R7 zero write ignored without dma", s[1], 1);
    wr(2'd0, 8'h3C);
    rd(2'd1, s);
    chk("R6 two-step clear", s[1], 0);
    wait_dec(2);
    chk("R2 byte 3C", (dec_q.size() > 1) ? dec_q[1] : 0, 8'h3C);
    idle(100);
    wr(2'd0, 8'h5A);
    idle(2);
    rd(2'd1, s);
    chk("R6 write without read keeps done", s[1], 1);
    wait_dec(3);
    chk("R2 byte 5A", (dec_q.size() > 2) ? dec_q[2] : 0, 8'h5A);
    idle(100);

    // R7/R8/R9: DMA mode, clock output off
    r0 = ck_rises;
    wr(2'd2, 8'h07);
    idle(2);
    chk("R8 dma_req with empty", dma_req, 1);
    wr(2'd1, 8'h00);
    rd(2'd1, s);
    chk("R7 zero write clears with dma", s[1], 0);
    wr(2'd0, 8'h81);
    chk("R8 dma_req low after write", dma_req, 0);
    @(negedge clk);
    chk("R8 dma_req back after load", dma_req, 1);
    wait_dec(4);
    chk("R2 byte 81", (dec_q.size() > 3) ? dec_q[3] : 0, 8'h81);
    idle(100);
    chk("R9 no ck when disabled", ck_rises - r0, 0);

    // R9 clock output on
    wr(2'd2, 8'h13);
    r0 = ck_rises;
    wr(2'd0, 8'h96);
    wait_dec(5);
    idle(100);
    chk("R2 byte 96", (dec_q.size() > 4) ? dec_q[4] : 0, 8'h96);
    chk("R9 ck pulses per frame", ck_rises - r0, 8);

    // R10 flow control
    wr(2'd2, 8'h0B);
    cts_n = 1'b1;
    wr(2'd0, 8'h11);
    idle(1500);
    chk("R10 held by cts", dec_q.size(), 5);
    rd(2'd1, s);
    chk("R10 byte still waiting", s[0], 0);
    cts_n = 1'b0;
    wait_dec(6);
    chk("R10 byte 11 after cts", (dec_q.size() > 5) ? dec_q[5] : 0, 8'h11);
    idle(100);
    wr(2'd0, 8'h22);
    idle(100);
    cts_n = 1'b1;
    wait_dec(7);
    chk("R10 frame completes despite cts", (dec_q.size() > 6) ? dec_q[6] : 0, 8'h22);
    chk("R10 frame shape 22", (dec_ok.size() > 6) ? dec_ok[6] : 0, 1);
    cts_n = 1'b0;
    idle(100);

    // R11 disable mid-frame
    wr(2'd2, 8'h03);
    wr(2'd0, 8'h44);
    idle(200);
    wr(2'd2, 8'h01);
    wait_dec(8);
    chk("R11 frame intact after disable", (dec_q.size() > 7) ? dec_q[7] : 0, 8'h44);
    chk("R11 frame shape 44", (dec_ok.size() > 7) ? dec_ok[7] : 0, 1);
    idle(100);
    wr(2'd0, 8'h55);
    idle(1500);
    chk("R11 no frame while disabled", dec_q.size(), 8);
    rd(2'd1, s);
    chk("R11 byte waiting while disabled", s[0], 0);

    // R3 re-enable sends idle frame again
    t_en = cyc;
    wr(2'd2, 8'h03);
    wait_dec(9);
    chk("R3 byte 55 after re-enable", (dec_q.size() > 8) ? dec_q[8] : 0, 8'h55);
    chk("R3 idle frame on re-enable",
        (dec_t.size() > 8) && (dec_t[8] - t_en >= 600) && (dec_t[8] - t_en <= 730), 1);
    idle(50);
    finish_run();
  end
endmodule